// File: doc/BRIEF.md
# Linear Sensor Pixel Readout Sequencer

This block is the digital control core of a line-scan image sensor with a shared sample-and-hold. A single-cycle start pulse, sampled on a rising clock edge while the block is idle, launches a readout frame: a global hold strobe freezes every pixel sample in the same cycle, a token enters a chain with one stage per pixel and walks one stage per clock, and a select line (one-hot and as a binary index) tells the analog side which pixel to put on the shared output. An output-enable stands in for the analog output leaving its high-impedance state.

While the pixels are read out, the integrators are held in reset for a fixed window of clocks counted from the start, after which the next exposure begins and continues until the next frame's hold. The token leaves the chain on the clock after the last pixel, which returns the block to idle; only then can a new start be taken. Start pulses that land inside a frame are dropped and flagged.

Top module: `lsr_readout_seq`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, hold, integrator reset, integrating flag, select, index, output-enable and error all read 0.
- R2: A start sampled high on a rising edge while no pixel is selected begins a frame: after that edge pixel 1 is selected (index 1, select bit 0 set).
- R3: The hold strobe is high for exactly one cycle, the cycle in which pixel 1 is selected.
- R4: The index advances by one per clock from 1 to the pixel count (default 102); the select is one-hot with bit index-1 set while the index is nonzero, and all zero with index 0 when idle.
- R5: The integrator reset output is high for the first 18 cycles of a frame (index 1 to 18) and low otherwise.
- R6: The integrating flag is low from reset until a frame reaches its 19th clock (index 19), then stays high until the hold of the next frame, in whose cycle it is low.
- R7: Output-enable is high exactly while a pixel is selected; the edge after the last pixel (the 103rd clock of the frame) returns the index to 0 and output-enable to low.
- R8: A start sampled on the 103rd clock of a frame is ignored and flagged; a start sampled on the 104th clock begins a new frame.
- R9: A start sampled while a pixel is selected is ignored: the readout keeps advancing unchanged, and the error output is high for the one cycle following each such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Serial start pulse, sampled on rising edges |
| hold_o | output | 1 | Global sample-and-hold strobe, one cycle per frame |
| int_rst_o | output | 1 | Integrator reset window |
| integ_o | output | 1 | Exposure in progress |
| sel_o | output | 102 | One-hot pixel select, bit 0 is pixel 1 |
| pix_idx_o | output | 7 | Selected pixel number, 0 when idle |
| out_en_o | output | 1 | Output drive enable, low stands for high impedance |
| err_o | output | 1 | Pulse marking a start dropped during a frame |

## Verification
On every cycle the assertions hold the one-hot chain against the separately counted index, output-enable against the select, the hold against the sampled start, the reset window and integration flag against the index, and each error pulse against a start seen mid-frame. What only the bench's scenarios show is the exact cycle count of a whole frame, the 103rd/104th-clock boundary for a new start, a flag that stays high across frames, and the behaviour of a start held high over several edges or a reset that lands mid-frame.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  // default geometry of the sensor line
  localparam int unsigned PIX_COUNT_DEF = 102;
  localparam int unsigned RST_WIN_DEF   = 18;

  // exposure phase of the integrator bank
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RESET = 2'd1,
    PH_INTEG = 2'd2
  } phase_t;
endpackage

// File: rtl/lsr_rst_sync.sv
module lsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/lsr_token_chain.sv
module lsr_token_chain #(
  parameter int unsigned NUM_PIX = lsr_pkg::PIX_COUNT_DEF
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               inject_i,
  output logic [NUM_PIX-1:0] stage_o
);
  logic [NUM_PIX-1:0] stage_q;
  logic [NUM_PIX-1:0] stage_d;

  // one token stage per pixel; the last stage drops out of the chain
  always_comb stage_d[0] = inject_i;
  generate
    for (genvar g = 1; g < NUM_PIX; g++) begin : g_stage
      always_comb stage_d[g] = stage_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign stage_o = stage_q;

  a_r4_chain_onehot: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(stage_q))
    else $error("token chain holds more than one token");
endmodule

// File: rtl/lsr_pix_counter.sv
module lsr_pix_counter #(
  parameter int unsigned NUM_PIX = lsr_pkg::PIX_COUNT_DEF,
  localparam int unsigned IDX_W  = $clog2(NUM_PIX + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PIX);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = 1'b0;
    idx_d  = idx_q;
    if (load_i) begin
      idx_en = 1'b1;
      idx_d  = IDX_W'(1);
    end else if (idx_q == LAST) begin
      idx_en = 1'b1;
      idx_d  = '0;
    end else if (idx_q != '0) begin
      idx_en = 1'b1;
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign busy_o = (idx_q != '0);

  a_r7_frame_ends: assert property (@(posedge clk) disable iff (!rst_ni)
    (idx_q == LAST) |=> (idx_q == '0))
    else $error("index did not return to idle after last pixel");

  a_r2_load_only_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |-> (idx_q == '0))
    else $error("frame load while busy");
endmodule

// File: rtl/lsr_window_ctl.sv
module lsr_window_ctl #(
  parameter int unsigned RST_CLKS = lsr_pkg::RST_WIN_DEF,
  localparam int unsigned CNT_W   = (RST_CLKS > 1) ? $clog2(RST_CLKS) : 1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic begin_i,
  output logic hold_o,
  output logic int_rst_o,
  output logic integ_o
);
  import lsr_pkg::*;

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             hold_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (begin_i) begin
      ph_d   = PH_RESET;
      cnt_d  = CNT_W'(RST_CLKS - 1);
      cnt_en = 1'b1;
    end else if (ph_q == PH_RESET) begin
      if (cnt_q == '0) begin
        ph_d = PH_INTEG;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      hold_q <= begin_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign hold_o    = hold_q;
  assign int_rst_o = (ph_q == PH_RESET);
  assign integ_o   = (ph_q == PH_INTEG);

  a_r5_rst_excl_integ: assert property (@(posedge clk) disable iff (!rst_ni)
    !(int_rst_o && integ_o))
    else $error("reset window overlaps integration");

  a_r3_hold_opens_window: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_q |-> (int_rst_o && cnt_q == CNT_W'(RST_CLKS - 1)))
    else $error("hold without fresh reset window");
endmodule

// File: rtl/lsr_readout_seq.sv
module lsr_readout_seq #(
  parameter int unsigned NUM_PIX  = lsr_pkg::PIX_COUNT_DEF,
  parameter int unsigned RST_CLKS = lsr_pkg::RST_WIN_DEF,
  localparam int unsigned IDX_W   = $clog2(NUM_PIX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               hold_o,
  output logic               int_rst_o,
  output logic               integ_o,
  output logic [NUM_PIX-1:0] sel_o,
  output logic [IDX_W-1:0]   pix_idx_o,
  output logic               out_en_o,
  output logic               err_o
);
  logic             rst_ni;
  logic             busy;
  logic             accept;
  logic             drop;
  logic             err_q;
  logic [IDX_W-1:0] idx;
  logic [NUM_PIX-1:0] stage;

  lsr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  // a start is taken only when no pixel is being presented
  always_comb begin
    accept = start_i && !busy;
    drop   = start_i &&  busy;
  end

  lsr_token_chain #(.NUM_PIX(NUM_PIX)) u_chain (
    .clk(clk), .rst_ni(rst_ni), .inject_i(accept), .stage_o(stage)
  );

  lsr_pix_counter #(.NUM_PIX(NUM_PIX)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .load_i(accept), .idx_o(idx), .busy_o(busy)
  );

  lsr_window_ctl #(.RST_CLKS(RST_CLKS)) u_win (
    .clk(clk), .rst_ni(rst_ni), .begin_i(accept),
    .hold_o(hold_o), .int_rst_o(int_rst_o), .integ_o(integ_o)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= drop;
  end

  assign sel_o     = stage;
  assign pix_idx_o = idx;
  assign out_en_o  = busy;
  assign err_o     = err_q;

  a_r4_sel_matches_idx: assert property (@(posedge clk) disable iff (!rst_ni)
    (idx != '0) |-> stage[idx - 1'b1])
    else $error("select bit does not match index");

  a_r7_oe_tracks_sel: assert property (@(posedge clk) disable iff (!rst_ni)
    out_en_o == (|stage))
    else $error("output enable without selected pixel");

  a_r3_hold_at_first: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_o |-> (idx == IDX_W'(1) && $past(start_i)))
    else $error("hold outside first pixel");

  a_r5_window_span: assert property (@(posedge clk) disable iff (!rst_ni)
    int_rst_o |-> (idx >= IDX_W'(1) && idx <= IDX_W'(RST_CLKS)))
    else $error("integrator reset outside window");

  a_r6_integ_rise: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(integ_o) |-> (idx == IDX_W'(RST_CLKS + 1)))
    else $error("integration began on wrong clock");

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    err_o |-> ($past(start_i) && $past(out_en_o)))
    else $error("error without dropped start");

  a_r8_late_start: assert property (@(posedge clk) disable iff (!rst_ni)
    (idx == IDX_W'(NUM_PIX) && start_i) |=> (err_o && !out_en_o))
    else $error("start on closing clock not dropped");
endmodule

// File: tb/lsr_readout_seq_test.sv
`timescale 1ns/1ps
module lsr_readout_seq_test;
  localparam int NP = 102;
  localparam int NV = 8;
  // checkpoint clocks after the start edge, and flags {hold,irst,integ,oe}
  localparam int       VEC_T [NV] = '{1, 2, 18, 19, 50, 102, 103, 104};
  localparam logic [3:0] VEC_F [NV] = '{4'b1101, 4'b0101, 4'b0101, 4'b0011,
                                       4'b0011, 4'b0011, 4'b0010, 4'b0010};

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic hold_o, int_rst_o, integ_o, out_en_o, err_o;
  logic [NP-1:0] sel_o;
  logic [6:0] pix_idx_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsr_readout_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_o(hold_o),
    .int_rst_o(int_rst_o), .integ_o(integ_o), .sel_o(sel_o),
    .pix_idx_o(pix_idx_o), .out_en_o(out_en_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_sel(input string req, input int idx);
    logic [NP-1:0] e;
    e = '0;
    if (idx > 0) e[idx-1] = 1'b1;
    checks++;
    if (sel_o !== e) begin
      errors++;
      $display("FAIL %s sel got %h exp %h", req, sel_o, e);
    end
  endtask

  task automatic chk_idle(input string req, input int integ);
    chk(req, "idx", int'(pix_idx_o), 0);
    chk_sel(req, 0);
    chk(req, "hold", int'(hold_o), 0);
    chk(req, "irst", int'(int_rst_o), 0);
    chk(req, "integ", int'(integ_o), integ);
    chk(req, "oe", int'(out_en_o), 0);
    chk(req, "err", int'(err_o), 0);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk_idle("R1", 0);
    repeat (3) tick();
    chk_idle("R1", 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk_idle("R1", 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    start_i = 1'b0;
    rst_n = 1'b0;
    tick();
    do_reset();

    // frame walked against the checkpoint table (R2 R3 R4 R5 R6 R7)
    start_i = 1'b1;
    t = 0;
    for (int k = 0; k < NV; k++) begin
      while (t < VEC_T[k]) begin
        tick();
        start_i = 1'b0;
        t++;
      end
      chk("R4", "idx", int'(pix_idx_o), (t <= NP) ? t : 0);
      chk_sel("R4", (t <= NP) ? t : 0);
      chk("R3", "hold", int'(hold_o), int'(VEC_F[k][3]));
      chk("R5", "irst", int'(int_rst_o), int'(VEC_F[k][2]));
      chk("R6", "integ", int'(integ_o), int'(VEC_F[k][1]));
      chk("R7", "oe", int'(out_en_o), int'(VEC_F[k][0]));
      chk("R9", "err", int'(err_o), 0);
    end

    // mid-frame start dropped, late start dropped, start on clock 104 taken
    start_i = 1'b1;
    t = 0;
    tick(); start_i = 1'b0; t = 1;
    chk("R6", "integ at hold", int'(integ_o), 0);
    chk("R2", "idx", int'(pix_idx_o), 1);
    while (t < 5) begin tick(); t++; end
    start_i = 1'b1;
    tick(); start_i = 1'b0; t++;
    chk("R9", "err", int'(err_o), 1);
    chk("R9", "idx", int'(pix_idx_o), 6);
    chk("R9", "hold", int'(hold_o), 0);
    tick(); t++;
    chk("R9", "err end", int'(err_o), 0);
    chk("R9", "idx", int'(pix_idx_o), 7);
    while (t < NP) begin tick(); t++; end
    chk("R7", "idx last", int'(pix_idx_o), NP);
    start_i = 1'b1;
    tick(); t++;
    chk("R8", "err 103", int'(err_o), 1);
    chk("R8", "idx 103", int'(pix_idx_o), 0);
    chk("R7", "oe 103", int'(out_en_o), 0);
    tick(); start_i = 1'b0; t++;
    chk("R8", "idx 104", int'(pix_idx_o), 1);
    chk("R8", "hold 104", int'(hold_o), 1);
    chk("R8", "err 104", int'(err_o), 0);
    repeat (NP + 2) tick();
    chk_idle("R7", 1);

    // start held high over three edges
    start_i = 1'b1;
    tick();
    chk("R2", "idx", int'(pix_idx_o), 1);
    chk("R9", "err first", int'(err_o), 0);
    tick();
    chk("R3", "hold once", int'(hold_o), 0);
    chk("R9", "err second", int'(err_o), 1);
    chk("R9", "idx", int'(pix_idx_o), 2);
    tick();
    start_i = 1'b0;
    chk("R9", "err third", int'(err_o), 1);
    chk("R4", "idx", int'(pix_idx_o), 3);
    tick();
    chk("R9", "err clear", int'(err_o), 0);
    chk("R5", "irst", int'(int_rst_o), 1);

    // reset in the middle of a frame
    repeat (10) tick();
    do_reset();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule